// File: doc/BRIEF.md
# Programmable Video Blanking Generator

This block derives horizontal and vertical blanking strobes for a display video path from logic-level timing inputs. It measures the line period in pixel clocks between successive rising edges of the flyback input. It then raises horizontal blanking a programmable number of pixels before the next flyback edge is due, and drops it when flyback falls. Vertical blanking begins on the rising edge of vertical sync and lasts for a programmable number of lines. Lines are counted on flyback rising edges.

A clamp strobe is forwarded from either a dedicated clamp input or the horizontal sync input. Each blanking output has its own enable. Software writes the settings through a plain address/data/strobe port. The settings take effect together at the next vertical sync rising edge, so a frame never runs with a mix of old and new values. The block has no streaming data path, so every pin is a plain level or strobe. The generator keeps running as long as its timing inputs toggle.

Top module: `blank_gen`

## Requirements
- R1: Vertical blanking rises on a rising edge of vertical sync and only there. The width of the sync pulse has no effect. A new rising edge during blanking restarts the line count.
- R2: Vertical blanking lasts until N flyback rising edges have arrived after the vsync edge. N is taken from bits 6:0 of the line-count register, and values 0 to 2 are raised to 3. A flyback edge that coincides with the vsync edge is not counted.
- R3: Once the line length is known, horizontal blanking rises L pixel clocks before the predicted flyback rising edge. The line length is the count of clock cycles between the last two flyback rising edges. L is the lead register, which accepts 0 to 64. Written values above 64 are held as 64.
- R4: Horizontal blanking falls on the flyback falling edge.
- R5: Until two flyback rising edges have been seen after reset, horizontal blanking equals the synchronized flyback level.
- R6: Each blanking output is forced low while its enable bit is 0.
- R7: The clamp output copies the synchronized hsync input when the clamp-source bit is 1, and the synchronized clamp input when it is 0.
- R8: Every input passes two synchronizing flops. An input change appears on the clamp output, and on the pass-through blanking of R5, two clocks later. Changes that act through edge detection show three clocks later.
- R9: The register write port has three addresses. Address 0 is control: bit 0 enables hblank, bit 1 enables vblank, bit 2 selects hsync as the clamp source. Address 1 is the lead and address 2 is the line count; address 3 is ignored. Written values take effect only at the next vsync rising edge. After reset, both enables are set, the clamp source is the clamp input, the lead is 0 and the line count is 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | active-low reset |
| flyback_in | input | 1 | asynchronous horizontal flyback |
| vsync_in | input | 1 | asynchronous vertical sync |
| hsync_in | input | 1 | asynchronous horizontal sync |
| clamp_in | input | 1 | asynchronous clamp pulse |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 2 | register address |
| cfg_wdata | input | 8 | register write data |
| hblank_o | output | 1 | horizontal blanking strobe |
| vblank_o | output | 1 | vertical blanking strobe |
| clamp_o | output | 1 | selected clamp strobe |

## Verification
On every cycle, assertions check four things:
- vblank starts on a vsync edge;
- the line count in use never drops below three;
- a flyback falling edge always clears the horizontal state;
- the lead in use never exceeds 64, and the active settings change only on a vsync edge.

Some behaviours only the bench scenarios can show:
- the predicted hblank lead at every value from 0 to 64;
- the exact line count of vblank, including clamping, restarts and wide pulses;
- the pass-through before the line length is measured;
- the clamp source choice.

// File: rtl/blank_pkg.sv
package blank_pkg;
  localparam int LEAD_W    = 7;
  localparam int LINES_W   = 7;
  localparam int LEAD_MAX  = 64;
  localparam int LINES_MIN = 3;
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_LEAD  = 2'd1;
  localparam logic [ADDR_W-1:0] A_LINES = 2'd2;

  typedef struct packed {
    logic               hb_en;
    logic               vb_en;
    logic               clamp_hs;
    logic [LEAD_W-1:0]  lead;
    logic [LINES_W-1:0] lines;
  } blank_cfg_t;

  localparam blank_cfg_t CFG_RESET = '{
    hb_en: 1'b1, vb_en: 1'b1, clamp_hs: 1'b0,
    lead: 7'd0, lines: 7'd10
  };
endpackage

// File: rtl/blank_sync.sv
module blank_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], din[i]};
    end
    assign lvl[i] = sr[STAGES-1];
  end
endmodule

// File: rtl/blank_edge.sv
module blank_edge #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse_o
);
  logic lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  if (FALLING) begin : g_fall
    assign pulse_o = lvl_d & ~lvl;
  end else begin : g_rise
    assign pulse_o = lvl & ~lvl_d;
  end
endmodule

// File: rtl/blank_cfg.sv
module blank_cfg
  import blank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              apply,
  output blank_cfg_t        act
);
  blank_cfg_t sh;
  logic [LEAD_W-1:0]  lead_w;
  logic [LINES_W-1:0] lines_w;

  always_comb begin
    lead_w  = (wdata > DATA_W'(LEAD_MAX)) ? LEAD_W'(LEAD_MAX) : wdata[LEAD_W-1:0];
    lines_w = (wdata[LINES_W-1:0] < LINES_W'(LINES_MIN)) ? LINES_W'(LINES_MIN)
                                                          : wdata[LINES_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= CFG_RESET;
      act <= CFG_RESET;
    end else begin
      if (we) begin
        case (addr)
          A_CTRL: begin
            sh.hb_en    <= wdata[0];
            sh.vb_en    <= wdata[1];
            sh.clamp_hs <= wdata[2];
          end
          A_LEAD:  sh.lead  <= lead_w;
          A_LINES: sh.lines <= lines_w;
          default: ;
        endcase
      end
      if (apply) act <= sh;
    end
  end

  // R9: active settings move only on a vsync edge
  a_r9_hold_until_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(act));
endmodule

// File: rtl/blank_hunit.sv
module blank_hunit
  import blank_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fb_lvl,
  input  logic              fb_rise,
  input  logic              fb_fall,
  input  logic [LEAD_W-1:0] lead,
  output logic              hb_out
);
  logic [CNT_W-1:0] cnt, cnt_nxt, len, target;
  logic [1:0]       seen;
  logic             hb_q, valid;

  assign valid   = seen[1];
  assign cnt_nxt = (&cnt) ? cnt : cnt + 1'b1;
  assign target  = (len > CNT_W'(lead)) ? len - CNT_W'(lead) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      len  <= '0;
      seen <= '0;
      hb_q <= 1'b0;
    end else begin
      if (fb_rise) begin
        cnt <= '0;
        len <= cnt_nxt;
        if (!seen[1]) seen <= seen + 1'b1;
      end else begin
        cnt <= cnt_nxt;
      end
      if (fb_rise)                             hb_q <= 1'b1;
      else if (fb_fall)                        hb_q <= 1'b0;
      else if (valid && (cnt_nxt == target))   hb_q <= 1'b1;
    end
  end

  assign hb_out = valid ? hb_q : fb_lvl;

  // R4: trailing flyback edge always ends the horizontal state
  a_r4_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fb_fall |=> !hb_q);
  // R3: lead in use never beyond the cap
  a_r3_lead_cap: assert property (@(posedge clk) disable iff (!rst_n)
    lead <= LEAD_W'(LEAD_MAX));
endmodule

// File: rtl/blank_vunit.sv
module blank_vunit
  import blank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vs_rise,
  input  logic               fb_rise,
  input  logic [LINES_W-1:0] lines,
  output logic               vb_out
);
  logic [LINES_W-1:0] cnt;
  logic [LINES_W:0]   cnt_inc;
  logic               vb_q;

  assign cnt_inc = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vb_q <= 1'b0;
      cnt  <= '0;
    end else if (vs_rise) begin
      vb_q <= 1'b1;
      cnt  <= '0;
    end else if (vb_q && fb_rise) begin
      cnt <= cnt_inc[LINES_W-1:0];
      if (cnt_inc == {1'b0, lines}) vb_q <= 1'b0;
    end
  end

  assign vb_out = vb_q;

  // R1: a vsync leading edge always opens vertical blanking
  a_r1_vs_starts: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> vb_q);
  // R2: the line count used while blanking is never below the floor
  a_r2_lines_floor: assert property (@(posedge clk) disable iff (!rst_n)
    vb_q |-> (lines >= LINES_W'(LINES_MIN)));
endmodule

// File: rtl/blank_gen.sv
module blank_gen
  import blank_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flyback_in,
  input  logic              vsync_in,
  input  logic              hsync_in,
  input  logic              clamp_in,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              hblank_o,
  output logic              vblank_o,
  output logic              clamp_o
);
  localparam int N_IN = 4;
  localparam int I_FB = 0;
  localparam int I_VS = 1;
  localparam int I_HS = 2;
  localparam int I_CL = 3;

  logic [N_IN-1:0] s;
  logic            fb_rise, fb_fall, vs_rise, hb_raw, vb_raw;
  blank_cfg_t      act;

  blank_sync #(.N(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({clamp_in, hsync_in, vsync_in, flyback_in}),
    .lvl(s)
  );

  blank_edge #(.FALLING(1'b0)) u_fb_rise (
    .clk(clk), .rst_n(rst_n), .lvl(s[I_FB]), .pulse_o(fb_rise));
  blank_edge #(.FALLING(1'b1)) u_fb_fall (
    .clk(clk), .rst_n(rst_n), .lvl(s[I_FB]), .pulse_o(fb_fall));
  blank_edge #(.FALLING(1'b0)) u_vs_rise (
    .clk(clk), .rst_n(rst_n), .lvl(s[I_VS]), .pulse_o(vs_rise));

  blank_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .apply(vs_rise), .act(act)
  );

  blank_hunit #(.CNT_W(CNT_W)) u_h (
    .clk(clk), .rst_n(rst_n), .fb_lvl(s[I_FB]), .fb_rise(fb_rise),
    .fb_fall(fb_fall), .lead(act.lead), .hb_out(hb_raw)
  );

  blank_vunit u_v (
    .clk(clk), .rst_n(rst_n), .vs_rise(vs_rise), .fb_rise(fb_rise),
    .lines(act.lines), .vb_out(vb_raw)
  );

  assign hblank_o = act.hb_en & hb_raw;
  assign vblank_o = act.vb_en & vb_raw;
  assign clamp_o  = act.clamp_hs ? s[I_HS] : s[I_CL];
endmodule

// File: tb/blank_gen_tb.sv
`timescale 1ns/1ps
module blank_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic flyback_in = 0, vsync_in = 0, hsync_in = 0, clamp_in = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0;
  logic hblank_o, vblank_o, clamp_o;

  always #2.5 clk = ~clk;

  blank_gen u_dut (
    .clk(clk), .rst_n(rst_n), .flyback_in(flyback_in), .vsync_in(vsync_in),
    .hsync_in(hsync_in), .clamp_in(clamp_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hblank_o(hblank_o), .vblank_o(vblank_o), .clamp_o(clamp_o)
  );

  int n = 0, P = 20, W = 4, ph = 0;
  int n_chk = 0, n_bad = 0;
  bit gen_on = 0, vs_d = 0, done = 0;
  bit chk_h = 0, chk_c = 0, chk_v = 0;
  bit sh_hen = 1, sh_ven = 1, sh_sel = 0;
  int sh_lead = 0, sh_lines = 10;
  bit act_hen = 1, act_ven = 1, act_sel = 0;
  int act_lead = 0, act_lines = 10;
  bit mvb = 0, vs_prev = 0, fb_prev = 0;
  int mcnt = 0;
  bit vbx[4];
  bit clx[4];
  int phh[4];

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at step %0d: got %b expected %b", req, n, act, exp);
    end
  endtask

  task automatic step();
    int q;
    bit fbv, hs, cl, vr, fr;
    @(negedge clk);
    if (chk_v && n >= 3) chk("R1/R2/R6 vblank", vblank_o, vbx[(n-3) & 3]);
    if (chk_h) begin
      q = phh[(n-3) & 3];
      chk("R3/R4/R6/R9 hblank", hblank_o, act_hen && (q < W || q >= P - act_lead));
    end
    if (chk_c) chk("R7/R8 clamp", clamp_o, clx[(n-2) & 3]);
    fbv = gen_on && (ph < W);
    hs  = (n % 7) < 2;
    cl  = (n % 5) == 0;
    flyback_in = fbv; vsync_in = vs_d; hsync_in = hs; clamp_in = cl;
    phh[n & 3] = ph;
    vr = vs_d && !vs_prev;
    fr = fbv && !fb_prev;
    if (vr) begin
      act_hen = sh_hen; act_ven = sh_ven; act_sel = sh_sel;
      act_lead = sh_lead; act_lines = sh_lines;
      mvb = 1; mcnt = 0;
    end else if (mvb && fr) begin
      mcnt++;
      if (mcnt == act_lines) mvb = 0;
    end
    vbx[n & 3] = mvb && act_ven;
    clx[n & 3] = act_sel ? hs : cl;
    vs_prev = vs_d; fb_prev = fbv;
    if (gen_on) ph = (ph + 1) % P;
    n++;
  endtask

  task automatic run(int k);
    repeat (k) step();
  endtask

  task automatic wr(int a, int d);
    cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = 8'(d);
    case (a)
      0: begin sh_hen = d[0]; sh_ven = d[1]; sh_sel = d[2]; end
      1: sh_lead = (d > 64) ? 64 : d;
      2: sh_lines = ((d & 127) < 3) ? 3 : (d & 127);
      default: ;
    endcase
    step();
    cfg_we = 0;
  endtask

  task automatic vpulse(int w);
    vs_d = 1; run(w); vs_d = 0;
  endtask

  task automatic to_phase(int p);
    while (ph != p) step();
  endtask

  initial begin
    int n0;
    run(4);
    rst_n = 1;
    run(2);
    chk("reset hblank", hblank_o, 1'b0);
    chk("reset vblank", vblank_o, 1'b0);
    chk("reset clamp", clamp_o, 1'b0);
    chk_v = 1;
    // R5/R8: pass-through before line length is known
    gen_on = 1;
    n0 = n;
    run(2);
    chk("R8 latency hblank", hblank_o, 1'b0);
    step();
    chk("R5 pass-through rise", hblank_o, 1'b1);
    run(W);
    chk("R5 pass-through fall", hblank_o, 1'b0);
    if (n != n0 + W + 3) $display("bench step count mismatch");
    run(3 * P);
    // R3/R4 lead sweep, including capped writes
    to_phase(0); P = 80; W = 6;
    for (int i = 0; i < 67; i++) begin
      wr(1, (i <= 64) ? i : ((i == 65) ? 70 : 200));
      to_phase(30); vpulse(2);
      run(2 * P); chk_h = 1; run(2 * P); chk_h = 0;
    end
    // R6 enables
    wr(0, 2); to_phase(30); vpulse(2);
    run(2 * P); chk_h = 1; run(2 * P); chk_h = 0;
    wr(0, 1); to_phase(30); vpulse(2);
    run(4 * P);
    // R9 deferral: control change waits for vsync
    wr(0, 3); to_phase(30); vpulse(2); run(2 * P);
    chk_h = 1; wr(0, 0); run(3 * P); chk_h = 0;
    to_phase(30); vpulse(2); run(8);
    chk_h = 1; run(2 * P); chk_h = 0;
    wr(0, 3); to_phase(30); vpulse(2); run(2 * P);
    // R2 line count sweep with floor and bit 7 ignored
    to_phase(0); P = 20; W = 4;
    for (int i = 0; i < 11; i++) begin
      int d, e;
      d = (i < 6) ? i : ((i == 6) ? 7 : (i == 7) ? 9 : (i == 8) ? 12 : (i == 9) ? 127 : 200);
      e = ((d & 127) < 3) ? 3 : (d & 127);
      wr(2, d);
      to_phase((i * 7) % P);
      vpulse(2);
      run((e + 2) * P);
    end
    // R1: wide pulse, then restart while active
    wr(2, 4); to_phase(5); vpulse(3 * P); run(6 * P);
    wr(2, 6); to_phase(9); vpulse(2); run(3 * P);
    vpulse(2); run(8 * P);
    // R7 clamp source, with hblank at small lead
    wr(1, 3); wr(2, 10); wr(0, 3);
    to_phase(10); vpulse(2); run(2 * P);
    chk_c = 1; chk_h = 1; run(200); chk_c = 0; chk_h = 0;
    wr(0, 7); to_phase(10); vpulse(2); run(2 * P);
    chk_c = 1; chk_h = 1; run(200); chk_c = 0; chk_h = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule